// File: doc/BRIEF.md
# Serial Single-Adder Mixing Function Datapath

This block evaluates one quarter-state mixing function on four 32-bit state words (a, b, c, d) for a 512-bit-block hash compression core. Area is the only goal, so one modular adder, one message/constant XOR and one XOR-and-rotate path are shared. The six additions and four XOR-rotates run in ten consecutive clock cycles, one operation per cycle. Every temporary result lands in a 32-bit intermediate register, which is the datapath output.

A caller presents the four state words together with two message words and two constant words, and pulses a start strobe. The block holds the operands in a small internal 4-entry word file. It walks the fixed ten-step schedule and pulses done once the last step has been written. The caller then reads the updated words. Choosing the round permutation and sequencing the whole compression belong to the caller.

Top module: `mix_g_serial`

## Requirements
- R1: After reset, busy_o, done_o, res_o and all four word outputs are zero.
- R2: A start_i sampled high while busy_o is low loads a_i..d_i into the word file and latches m0_i, m1_i, k0_i and k1_i. busy_o is high from the next cycle.
- R3: After a start, busy_o stays high for exactly ten cycles. In each of these cycles one step runs, in this order: a+=b; a+=(m0^k1); d=(d^a)>>>16; c+=d; b=(b^c)>>>12; a+=b; a+=(m1^k0); d=(d^a)>>>8; c+=d; b=(b^c)>>>7. Here >>> is a rotation towards the least significant bit.
- R4: When done_o is high, a_o..d_o hold the complete mixing-function result for the loaded operands.
- R5: After each step's clock edge, res_o shows that step's result, which is the new value of the word the step wrote.
- R6: done_o is high for exactly one cycle, in the cycle after the tenth step, and busy_o is low in that cycle.
- R7: start_i while busy_o is high is ignored. The schedule, the results and the timing of done_o are unchanged.
- R8: All additions are modulo 2^32; carries out of bit 31 are dropped.
- R9: A start_i given in the cycle that done_o is high is accepted, so two evaluations can run back to back with no idle cycle.
- R10: While idle and with start_i low, res_o and a_o..d_o hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| a_i | input | 32 | State word a operand |
| b_i | input | 32 | State word b operand |
| c_i | input | 32 | State word c operand |
| d_i | input | 32 | State word d operand |
| m0_i | input | 32 | First message word |
| m1_i | input | 32 | Second message word |
| k0_i | input | 32 | First constant word |
| k1_i | input | 32 | Second constant word |
| busy_o | output | 1 | High while a step runs |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 32 | Intermediate result register |
| a_o | output | 32 | Current word a |
| b_o | output | 32 | Current word b |
| c_o | output | 32 | Current word c |
| d_o | output | 32 | Current word d |

## Verification
The assertions check the control behaviour on every cycle. They cover the accept rule for start, step advance and range, refusal of start while busy, the single-cycle done pulse that never coincides with busy, exclusive word-file writes, and holding while idle. The arithmetic can only be shown by the bench's scenarios: step order, rotation amounts, which message/constant pairing goes into each half, and modular wrap. The bench model predicts every intermediate value and final word for several operand patterns, including all-ones words, back-to-back starts and a start injected mid-run.

// File: rtl/mix_g_serial_pkg.sv
package mix_g_serial_pkg;
  localparam int unsigned N_STEPS = 10;
  localparam int unsigned STEP_W  = $clog2(N_STEPS);
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned IDX_W   = $clog2(N_WORDS);

  localparam logic [IDX_W-1:0] W_A = 2'd0;
  localparam logic [IDX_W-1:0] W_B = 2'd1;
  localparam logic [IDX_W-1:0] W_C = 2'd2;
  localparam logic [IDX_W-1:0] W_D = 2'd3;

  typedef enum logic [1:0] {OP_ADD_REG, OP_ADD_MK, OP_XROT} op_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
    logic [1:0]       rot;
    logic             mk_hi;
  } step_t;

  function automatic step_t decode_step(logic [STEP_W-1:0] s);
    step_t t;
    t = '{op: OP_ADD_REG, dst: W_A, src: W_B, rot: 2'd0, mk_hi: 1'b0};
    case (s)
      4'd0: t = '{op: OP_ADD_REG, dst: W_A, src: W_B, rot: 2'd0, mk_hi: 1'b0};
      4'd1: t = '{op: OP_ADD_MK,  dst: W_A, src: W_B, rot: 2'd0, mk_hi: 1'b0};
      4'd2: t = '{op: OP_XROT,    dst: W_D, src: W_A, rot: 2'd0, mk_hi: 1'b0};
      4'd3: t = '{op: OP_ADD_REG, dst: W_C, src: W_D, rot: 2'd0, mk_hi: 1'b0};
      4'd4: t = '{op: OP_XROT,    dst: W_B, src: W_C, rot: 2'd1, mk_hi: 1'b0};
      4'd5: t = '{op: OP_ADD_REG, dst: W_A, src: W_B, rot: 2'd0, mk_hi: 1'b1};
      4'd6: t = '{op: OP_ADD_MK,  dst: W_A, src: W_B, rot: 2'd0, mk_hi: 1'b1};
      4'd7: t = '{op: OP_XROT,    dst: W_D, src: W_A, rot: 2'd2, mk_hi: 1'b1};
      4'd8: t = '{op: OP_ADD_REG, dst: W_C, src: W_D, rot: 2'd0, mk_hi: 1'b1};
      4'd9: t = '{op: OP_XROT,    dst: W_B, src: W_C, rot: 2'd3, mk_hi: 1'b1};
      default: ;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/mix_ctrl.sv
module mix_ctrl
  import mix_g_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              load_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  assign load_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (step_o == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          step_o <= '0;
        end else begin
          step_o <= step_o + 1'b1;
        end
      end else if (start_i) begin
        busy_o <= 1'b1;
        step_o <= '0;
      end
    end
  end

  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && step_o == '0);
  a_r3_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> step_o <= LAST);
  a_r7_busy_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && step_o != LAST |=> busy_o && step_o == $past(step_o) + 1'b1);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && step_o == LAST |=> done_o);
endmodule

// File: rtl/mix_regfile.sv
module mix_regfile #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 4,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [N-1:0][W-1:0] load_data_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [AW-1:0]     raddr0_i,
  input  logic [AW-1:0]     raddr1_i,
  output logic [W-1:0]      rdata0_o,
  output logic [W-1:0]      rdata1_o,
  output logic [N-1:0][W-1:0] words_o
);
  logic [N-1:0] wsel;

  for (genvar g = 0; g < N; g++) begin : g_word
    assign wsel[g] = we_i && (waddr_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      words_o[g] <= '0;
      else if (load_i)  words_o[g] <= load_data_i[g];
      else if (wsel[g]) words_o[g] <= wdata_i;
    end
  end

  assign rdata0_o = words_o[raddr0_i];
  assign rdata1_o = words_o[raddr1_i];

  a_r3_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wsel) && !(load_i && we_i));
endmodule

// File: rtl/mix_alu.sv
module mix_alu
  import mix_g_serial_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned ROT0 = 16,
  parameter int unsigned ROT1 = 12,
  parameter int unsigned ROT2 = 8,
  parameter int unsigned ROT3 = 7
) (
  input  op_e        op_i,
  input  logic [1:0] rot_i,
  input  logic       mk_hi_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] m0_i,
  input  logic [W-1:0] m1_i,
  input  logic [W-1:0] k0_i,
  input  logic [W-1:0] k1_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0]      mk, add_b, sum, xr;
  logic [3:0][W-1:0] rots;

  // message/constant XOR unit: the pairing swaps in the second half
  assign mk    = mk_hi_i ? (m1_i ^ k0_i) : (m0_i ^ k1_i);
  assign add_b = (op_i == OP_ADD_MK) ? mk : y_i;
  assign sum   = x_i + add_b;
  assign xr    = x_i ^ y_i;

  for (genvar g = 0; g < 4; g++) begin : g_rot
    localparam int unsigned AMT = (g == 0) ? ROT0 : (g == 1) ? ROT1 :
                                  (g == 2) ? ROT2 : ROT3;
    assign rots[g] = (xr >> AMT) | (xr << (W - AMT));
  end

  assign res_o = (op_i == OP_XROT) ? rots[rot_i] : sum;
endmodule

// File: rtl/mix_g_serial.sv
module mix_g_serial
  import mix_g_serial_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] m0_i,
  input  logic [W-1:0] m1_i,
  input  logic [W-1:0] k0_i,
  input  logic [W-1:0] k1_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] d_o
);
  logic                       load;
  logic [STEP_W-1:0]          step;
  step_t                      cur;
  logic [W-1:0]               x, y, alu_res;
  logic [W-1:0]               m0_q, m1_q, k0_q, k1_q;
  logic [N_WORDS-1:0][W-1:0]  words;

  mix_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step)
  );

  assign cur = decode_step(step);

  mix_regfile #(.W(W), .N(N_WORDS)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i ({d_i, c_i, b_i, a_i}),
    .we_i        (busy_o),
    .waddr_i     (cur.dst),
    .wdata_i     (alu_res),
    .raddr0_i    (cur.dst),
    .raddr1_i    (cur.src),
    .rdata0_o    (x),
    .rdata1_o    (y),
    .words_o     (words)
  );

  mix_alu #(.W(W)) u_alu (
    .op_i    (cur.op),
    .rot_i   (cur.rot),
    .mk_hi_i (cur.mk_hi),
    .x_i     (x),
    .y_i     (y),
    .m0_i    (m0_q),
    .m1_i    (m1_q),
    .k0_i    (k0_q),
    .k1_i    (k1_q),
    .res_o   (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m0_q  <= '0;
      m1_q  <= '0;
      k0_q  <= '0;
      k1_q  <= '0;
      res_o <= '0;
    end else begin
      if (load) begin
        m0_q <= m0_i;
        m1_q <= m1_i;
        k0_q <= k0_i;
        k1_q <= k1_i;
      end
      if (busy_o) res_o <= alu_res;
    end
  end

  assign a_o = words[W_A];
  assign b_o = words[W_B];
  assign c_o = words[W_C];
  assign d_o = words[W_D];

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(res_o) && $stable(words));
  a_r7_mk_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(m0_q) && $stable(m1_q) && $stable(k0_q) && $stable(k1_q));
  a_r5_res_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> res_o == words[$past(cur.dst)]);
endmodule

// File: tb/mix_g_serial_tb.sv
module mix_g_serial_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0;
  logic [31:0] m0_in = '0, m1_in = '0, k0_in = '0, k1_in = '0;
  logic        busy, done;
  logic [31:0] res, a_out, b_out, c_out, d_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mix_g_serial u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a_in), .b_i(b_in), .c_i(c_in), .d_i(d_in),
    .m0_i(m0_in), .m1_i(m1_in), .k0_i(k0_in), .k1_i(k1_in),
    .busy_o(busy), .done_o(done), .res_o(res),
    .a_o(a_out), .b_o(b_out), .c_o(c_out), .d_o(d_out)
  );

  function automatic logic [31:0] ror(logic [31:0] v, int n);
    return (v >> n) | (v << (32 - n));
  endfunction

  // whole mixing function in one go, R4/R8
  function automatic logic [127:0] gfun(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                        logic [31:0] d, logic [31:0] m0, logic [31:0] m1,
                                        logic [31:0] k0, logic [31:0] k1);
    a = a + b + (m0 ^ k1);
    d = ror(d ^ a, 16);
    c = c + d;
    b = ror(b ^ c, 12);
    a = a + b + (m1 ^ k0);
    d = ror(d ^ a, 8);
    c = c + d;
    b = ror(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  // cycle model
  logic [31:0] ea, eb, ec, ed, eres, em0, em1, ek0, ek1;
  logic ebusy, edone;
  int   estep;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ea, eb, ec, ed, eres} = '0;
      {em0, em1, ek0, ek1} = '0;
      ebusy = 1'b0; edone = 1'b0; estep = 0;
    end else begin
      edone = 1'b0;
      if (ebusy) begin
        case (estep)
          0: begin ea = ea + eb;          eres = ea; end
          1: begin ea = ea + (em0 ^ ek1); eres = ea; end
          2: begin ed = ror(ed ^ ea, 16); eres = ed; end
          3: begin ec = ec + ed;          eres = ec; end
          4: begin eb = ror(eb ^ ec, 12); eres = eb; end
          5: begin ea = ea + eb;          eres = ea; end
          6: begin ea = ea + (em1 ^ ek0); eres = ea; end
          7: begin ed = ror(ed ^ ea, 8);  eres = ed; end
          8: begin ec = ec + ed;          eres = ec; end
          default: begin eb = ror(eb ^ ec, 7); eres = eb; end
        endcase
        estep++;
        if (estep == 10) begin ebusy = 1'b0; edone = 1'b1; end
      end else if (start) begin
        ea = a_in; eb = b_in; ec = c_in; ed = d_in;
        em0 = m0_in; em1 = m1_in; ek0 = k0_in; ek1 = k1_in;
        ebusy = 1'b1; estep = 0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compared on every clock: R2 R3 R5 R6 R7 R10
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 busy", {31'b0, busy}, {31'b0, ebusy});
      check("R6 done", {31'b0, done}, {31'b0, edone});
      check("R5 res", res, eres);
      check("R2 word a", a_out, ea);
      check("R2 word b", b_out, eb);
      check("R2 word c", c_out, ec);
      check("R2 word d", d_out, ed);
    end
  end

  task automatic launch(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] d,
                        logic [31:0] m0, logic [31:0] m1, logic [31:0] k0, logic [31:0] k1);
    a_in = a; b_in = b; c_in = c; d_in = d;
    m0_in = m0; m1_in = m1; k0_in = k0; k1_in = k1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_final(string tag, logic [127:0] exp);
    check(tag, a_out, exp[127:96]);
    check(tag, b_out, exp[95:64]);
    check(tag, c_out, exp[63:32]);
    check(tag, d_out, exp[31:0]);
  endtask

  task automatic run_one(string tag, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         logic [31:0] d, logic [31:0] m0, logic [31:0] m1,
                         logic [31:0] k0, logic [31:0] k1);
    int n;
    launch(a, b, c, d, m0, m1, k0, k1);
    n = 1;
    while (!done) begin @(negedge clk); n++; end
    check("R3 ten busy cycles", n, 11);
    check_final(tag, gfun(a, b, c, d, m0, m1, k0, k1));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 res", res, 32'd0);
    check("R1 words", a_out | b_out | c_out | d_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one("R4 basic", 32'h6a09e667, 32'h510e527f, 32'h243f6a88, 32'h13198a2e,
            32'h00010203, 32'h04050607, 32'h85a308d3, 32'h03707344);
    run_one("R4 zeros", '0, '0, '0, '0, '0, '0, '0, '0);
    // R8 wraps on every addition
    run_one("R8 all ones", 32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff,
            32'hffffffff, 32'h0, 32'hffffffff, 32'h0);
    run_one("R4 single bit", 32'h1, 32'h0, 32'h0, 32'h80000000,
            32'h0, 32'h1, 32'h0, 32'h0);

    // R10 idle with noisy inputs and start low
    a_in = 32'hdeadbeef; m0_in = 32'hcafef00d;
    repeat (5) @(negedge clk);
    check_final("R10 idle hold", gfun(32'h1, 32'h0, 32'h0, 32'h80000000,
                                      32'h0, 32'h1, 32'h0, 32'h0));

    // R7 start pulses while busy
    launch(32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444,
           32'h55555555, 32'h66666666, 32'h77777777, 32'h88888888);
    repeat (3) @(negedge clk);
    launch(32'h9, 32'h9, 32'h9, 32'h9, 32'h9, 32'h9, 32'h9, 32'h9);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_done();
    check_final("R7 start ignored", gfun(32'h11111111, 32'h22222222, 32'h33333333,
                32'h44444444, 32'h55555555, 32'h66666666, 32'h77777777, 32'h88888888));

    // R9 back to back start in the done cycle
    launch(32'hf0f0f0f0, 32'h0f0f0f0f, 32'h12345678, 32'h9abcdef0,
           32'h13579bdf, 32'h2468ace0, 32'hfedcba98, 32'h76543210);
    @(negedge clk);
    check("R9 busy after back to back", {31'b0, busy}, 32'd1);
    wait_done();
    check_final("R9 second run", gfun(32'hf0f0f0f0, 32'h0f0f0f0f, 32'h12345678,
                32'h9abcdef0, 32'h13579bdf, 32'h2468ace0, 32'hfedcba98, 32'h76543210));
    @(negedge clk);
    check("R6 done one cycle", {31'b0, done}, 32'd0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule